// File: doc/BRIEF.md
# Data EEPROM Control Register Unit

This block is the register front end that a small microcontroller core uses to reach an on-chip data EEPROM. The core sees four byte-wide registers: a control register, a storage-less unlock register, an address register and a data register. It chooses one with a two-bit select and writes it with a one-cycle strobe. Reads are combinational from the select. Setting the read trigger copies one array word into the data register in a single cycle. Setting the write trigger starts a timed write that lasts a fixed number of clocks, after which the word is committed and a sticky completion flag rises.

A write starts only when three conditions hold. The write-enable bit must already be set. The two bus writes just before the trigger must have put 0x55 and then 0xAA into the unlock register. No write may already be in progress. While a write is in progress, the address, data and control registers are frozen, except that the write-enable bit may still be cleared. A warm reset (master clear, watchdog or brown-out, merged onto one synchronous input) that arrives during a write has four effects. It abandons the write and sets a sticky error bit that survives the reset. It clears the address and data registers. It leaves the array word untouched. A power-on reset clears everything, including the error bit. The array is modelled inside the block as a plain synchronous memory.

Top module: `eectl_unit`

## Requirements
- R1: Select codes are 0 for control, 1 for unlock, 2 for address and 3 for data. In the control register, bit 0 is the read trigger, bit 1 is the write trigger, bit 2 is the write enable and bit 3 is the error bit. Bits 7..4 always read 0.
- R2: Writing a 0 to a trigger bit has no effect. Only the hardware clears a trigger.
- R3: Writing control with bit 0 set raises the read trigger for exactly one cycle. After that cycle the data register holds the array word at the current address. The read trigger is not raised if the same write starts a write cycle.
- R4: While write enable is 0, setting the write trigger is ignored and the array is not changed. Write enable is 0 after power-on.
- R5: The write trigger is accepted only if the two immediately preceding bus writes put 0x55 and then 0xAA into the unlock register. Any other order, or any bus write in between, makes the attempt ignored.
- R6: The unlock register reads 0 at all times.
- R7: A started write holds the write trigger at 1 for exactly WR_CYCLES cycles. It then clears the trigger, commits the data register to the array at the address register, and sets the completion flag.
- R8: The completion flag stays set until `flag_clr` is pulsed. Power-on clears it.
- R9: While a write is in progress, writes to the address and data registers are ignored. A control write may only clear write enable, and it cannot clear the write trigger.
- R10: A warm reset while the write trigger is 1 has four effects. It sets the error bit. It clears the write trigger, write enable, address and data. It leaves the array word unchanged. It does not set the completion flag.
- R11: A write that completes normally leaves the error bit at 0. Software can also clear the error bit by writing control bit 3 as 0 while idle.
- R12: The error bit keeps its value through a warm reset when no write is in progress. A power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wrst | input | 1 | Synchronous active-high warm reset (master clear, watchdog, brown-out) |
| bus_sel | input | 2 | Register select: 0 control, 1 unlock, 2 address, 3 data |
| bus_we | input | 1 | One-cycle register write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data of the selected register |
| done_flag | output | 1 | Sticky write-complete flag |
| flag_clr | input | 1 | Clears the write-complete flag |

## Verification
A wrong busy counter shows up at the control port as a write-trigger bit that stays high for too many or too few cycles. A run of polls starting right after the start edge detects this on the exact cycle it happens. A corrupted unlock tracker or write-enable latch is visible one cycle after the trigger write, as a trigger bit that was accepted or refused when it should not have been. A bad abort path can do three wrong things: drop the error bit, keep the address or data, or commit the word. The first two show at the next control or address read. The third shows at the next array read-back of that location.

// File: rtl/eectl_unit.sv
module eectl_unit #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wrst,
  input  logic [1:0]        bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              done_flag,
  input  logic              flag_clr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_UNL = 2'd1;
  localparam logic [1:0] SEL_ADR = 2'd2;
  localparam logic [1:0] SEL_DAT = 2'd3;

  logic              rd_q, wr_q, wren_q, wrerr_q;
  logic              key1_q, armed_q, flag_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] mem [DEPTH];

  wire ctl_we = bus_we && bus_sel == SEL_CTL;
  wire unl_we = bus_we && bus_sel == SEL_UNL;
  wire adr_we = bus_we && bus_sel == SEL_ADR;
  wire dat_we = bus_we && bus_sel == SEL_DAT;
  wire start  = ctl_we && bus_wdata[1] && wren_q && armed_q && !wr_q;
  wire done   = wr_q && cnt_q == '0;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_q <= 1'b0; wr_q <= 1'b0; wren_q <= 1'b0; wrerr_q <= 1'b0;
      key1_q <= 1'b0; armed_q <= 1'b0;
      addr_q <= '0; data_q <= '0; cnt_q <= '0;
    end else if (wrst) begin
      wrerr_q <= wrerr_q | wr_q;
      rd_q <= 1'b0; wr_q <= 1'b0; wren_q <= 1'b0;
      key1_q <= 1'b0; armed_q <= 1'b0;
      addr_q <= '0; data_q <= '0; cnt_q <= '0;
    end else begin
      if (bus_we) begin
        key1_q  <= unl_we && bus_wdata[7:0] == 8'h55;
        armed_q <= unl_we && bus_wdata[7:0] == 8'hAA && key1_q;
      end
      if (rd_q) begin
        rd_q   <= 1'b0;
        data_q <= mem[addr_q];
      end else if (dat_we && !wr_q) begin
        data_q <= bus_wdata;
      end
      if (wr_q) begin
        if (ctl_we) wren_q <= wren_q & bus_wdata[2];
        if (done) begin
          wr_q    <= 1'b0;
          wrerr_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else begin
        if (adr_we) addr_q <= bus_wdata[ADDR_W-1:0];
        if (ctl_we) begin
          wren_q  <= bus_wdata[2];
          wrerr_q <= bus_wdata[3];
          if (bus_wdata[0] && !start) rd_q <= 1'b1;
          if (start) begin
            wr_q  <= 1'b1;
            cnt_q <= CNT_W'(WR_CYCLES - 1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) flag_q <= 1'b0;
    else if (done && !wrst) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (done && !wrst) mem[addr_q] <= data_q;
  end

  always_comb begin
    case (bus_sel)
      SEL_CTL: bus_rdata = DATA_W'({wrerr_q, wren_q, wr_q, rd_q});
      SEL_UNL: bus_rdata = '0;
      SEL_ADR: bus_rdata = DATA_W'(addr_q);
      default: bus_rdata = data_q;
    endcase
  end

  assign done_flag = flag_q;

  p_rd_pulse_r3: assert property (@(posedge clk) disable iff (!por_n)
    rd_q |=> !rd_q);

  // R5 as well: a start needs both enable and the unlock pair
  p_start_guard_r4: assert property (@(posedge clk) disable iff (!por_n)
    $rose(wr_q) |-> $past(wren_q && armed_q));

  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    (wr_q && cnt_q != '0 && !wrst) |=> wr_q);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
    (flag_q && !flag_clr) |=> flag_q);

  p_busy_frozen_r9: assert property (@(posedge clk) disable iff (!por_n)
    (wr_q && !wrst) |=> ($stable(addr_q) && $stable(data_q)));

  p_abort_err_r10: assert property (@(posedge clk) disable iff (!por_n)
    (wr_q && wrst) |=> (wrerr_q && !wr_q && addr_q == '0 && data_q == '0));

  p_done_clean_r11: assert property (@(posedge clk) disable iff (!por_n)
    (done && !wrst) |=> (!wrerr_q && !wr_q && flag_q));

endmodule

// File: tb/sim_eectl_unit.sv
module sim_eectl_unit;
  localparam int NCYC = 12;
  logic clk = 1'b0, por_n = 1'b0, wrst = 1'b0, bus_we = 1'b0, flag_clr = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic done_flag;
  int total = 0, bad = 0;
  bit finished = 0;

  eectl_unit #(.ADDR_W(6), .DATA_W(8), .WR_CYCLES(NCYC)) u0 (
    .clk(clk), .por_n(por_n), .wrst(wrst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_flag(done_flag),
    .flag_clr(flag_clr));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); bus_sel = s; bus_wdata = v; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic br(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s; #1; v = bus_rdata;
  endtask

  task automatic start_write(input logic [5:0] a, input logic [7:0] d, input logic [7:0] extra);
    bw(2, {2'b00, a}); bw(3, d); bw(0, 8'h04 | extra);
    bw(1, 8'h55); bw(1, 8'hAA); bw(0, 8'h06 | extra);
  endtask

  task automatic wait_done(output int n);
    n = 0; bus_sel = 0; #1;
    while (bus_rdata[1] && n < 1000) begin n++; @(negedge clk); #1; end
  endtask

  task automatic mem_read(input logic [5:0] a, output logic [7:0] v);
    logic [7:0] c;
    bw(2, {2'b00, a}); bw(0, 8'h00); bw(0, 8'h01);
    br(0, c); check(c[0] == 1'b1, "R3 read trigger high", c, 1);
    @(negedge clk); br(0, c); check(c[0] == 1'b0, "R3 read trigger self-clears", c, 0);
    br(3, v);
  endtask

  task automatic t_reset;
    logic [7:0] c;
    br(0, c); check(c == 8'h00, "R1 control after power-on", c, 0);
    check(done_flag == 1'b0, "R8 flag after power-on", done_flag, 0);
    bw(0, 8'hF4); br(0, c); check(c == 8'h04, "R1 upper bits zero, enable at bit 2", c, 8'h04);
    bw(1, 8'h55); br(1, c); check(c == 8'h00, "R6 unlock reads zero", c, 0);
    bw(0, 8'h00);
  endtask

  task automatic t_basic;
    int n; logic [7:0] v;
    start_write(6'd5, 8'h3C, 8'h00);
    wait_done(n); check(n == NCYC, "R7 busy length", n, NCYC);
    check(done_flag == 1'b1, "R7 flag on completion", done_flag, 1);
    br(0, v); check(v[3] == 1'b0, "R11 error clear after normal write", v, 0);
    mem_read(6'd5, v); check(v == 8'h3C, "R3 read-back", v, 8'h3C);
    check(done_flag == 1'b1, "R8 flag sticky", done_flag, 1);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    check(done_flag == 1'b0, "R8 flag cleared", done_flag, 0);
  endtask

  task automatic t_guards;
    logic [7:0] c; int n;
    bw(2, 8'd5); bw(3, 8'h11); bw(0, 8'h00); bw(1, 8'h55); bw(1, 8'hAA); bw(0, 8'h02);
    br(0, c); check(c[1] == 1'b0, "R4 enable low blocks write", c, 0);
    bw(0, 8'h04); bw(1, 8'h55); bw(2, 8'd5); bw(1, 8'hAA); bw(0, 8'h06);
    br(0, c); check(c[1] == 1'b0, "R5 interleaved write breaks unlock", c, 0);
    bw(1, 8'hAA); bw(1, 8'h55); bw(0, 8'h06);
    br(0, c); check(c[1] == 1'b0, "R5 wrong unlock order", c, 0);
    bw(0, 8'h06);
    br(0, c); check(c[1] == 1'b0, "R5 no unlock at all", c, 0);
    wait_done(n);
    mem_read(6'd5, c); check(c == 8'h3C, "R4 array unchanged by refused writes", c, 8'h3C);
  endtask

  task automatic t_busy;
    logic [7:0] c; int n;
    start_write(6'd9, 8'h77, 8'h00);
    bw(0, 8'h00); br(0, c);
    check(c[1] == 1'b1, "R2 zero write keeps write trigger", c, 1);
    check(c[2] == 1'b0, "R9 enable may clear while busy", c, 0);
    bw(0, 8'h0D); br(0, c); check(c == 8'h02, "R9 control frozen while busy", c, 8'h02);
    bw(2, 8'h20); bw(3, 8'hEE);
    br(2, c); check(c == 8'd9, "R9 address frozen", c, 9);
    br(3, c); check(c == 8'h77, "R9 data frozen", c, 8'h77);
    wait_done(n); check(n > 0 && n <= NCYC, "R7 busy completes", n, NCYC);
    mem_read(6'd9, c); check(c == 8'h77, "R9 committed original word", c, 8'h77);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_abort;
    logic [7:0] c; int n;
    start_write(6'd12, 8'h10, 8'h00); wait_done(n);
    @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    start_write(6'd12, 8'h44, 8'h00);
    repeat (3) @(negedge clk);
    wrst = 1'b1; @(negedge clk); wrst = 1'b0;
    br(0, c); check(c == 8'h08, "R10 error set, trigger and enable cleared", c, 8'h08);
    br(2, c); check(c == 8'h00, "R10 address cleared", c, 0);
    br(3, c); check(c == 8'h00, "R10 data cleared", c, 0);
    repeat (NCYC + 2) @(negedge clk);
    check(done_flag == 1'b0, "R10 no completion flag", done_flag, 0);
    wrst = 1'b1; @(negedge clk); wrst = 1'b0;
    br(0, c); check(c == 8'h08, "R12 error survives idle warm reset", c, 8'h08);
    mem_read(6'd12, c); check(c == 8'h10, "R10 array word unchanged", c, 8'h10);
    bw(0, 8'h00); br(0, c); check(c == 8'h00, "R11 software clears error", c, 0);
    start_write(6'd13, 8'h5A, 8'h08);
    br(0, c); check(c == 8'h0E, "R1 all low fields during write", c, 8'h0E);
    wait_done(n);
    br(0, c); check(c[3] == 1'b0, "R11 completion clears error", c, 0);
    bw(0, 8'h08); br(0, c); check(c == 8'h08, "R12 error set before power-on", c, 8'h08);
    @(negedge clk); por_n = 1'b0; @(negedge clk); por_n = 1'b1;
    br(0, c); check(c == 8'h00, "R12 power-on clears error", c, 0);
    check(done_flag == 1'b0, "R8 power-on clears flag", done_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_guards();
    t_busy();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule